// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block decides when a backup battery is put under a test load and whether that battery should be reported as weak. It runs from a clock with a known tick rate, so every delay is a count of ticks. One input says that the main supply is good. A second input carries the result of an external comparator that is high while the loaded battery reads below its trip point. The block drives the enable for the test load. It also drives an open-drain warning: the single output bit turns the pull-down on or leaves the line released. The line is never driven high.

When the main supply becomes good, the block waits a recovery delay and then runs a test. It then runs a new test every interval, counted from the start of the previous test. A test holds the load on for a fixed window. The comparator is sampled on the last tick of that window. A weak reading sets the warning. A good reading from a periodic test leaves an existing warning in place. A good reading from the test that follows a power-up clears the warning. Loss of the supply stops all activity at once. A window that is cut short by power loss changes nothing. All pins are plain control levels and no data stream passes through the block, so no handshake is needed.

The parameters RECOVERY_TICKS, TEST_TICKS and INTERVAL_TICKS set the three delays. Short values can be used in simulation. INTERVAL_TICKS must be larger than TEST_TICKS.

Top module: `batt_monitor`

## Requirements
- R1: While reset is active, and right after it is released, load_en is 0 and warn_pull_low is 0 (line released), whatever value the warning had before the reset.
- R2: While supply_ok is 0, load_en stays 0 from the next tick on, and no test starts.
- R3: Say supply_ok is first sampled high at clock edge E0 and stays high. Then load_en rises right after edge E0+RECOVERY_TICKS. The power-up test runs even when the warning is already set.
- R4: If the supply stays good for the whole window, load_en stays high for exactly TEST_TICKS consecutive cycles.
- R5: Periodic tests start exactly INTERVAL_TICKS cycles after the start of the previous test. The count is restarted at every test start, including the power-up test.
- R6: If batt_low is 1 at the clock edge that ends a window, warn_pull_low is 1 from that edge on. Here 1 means the pull-down is on.
- R7: A periodic test that ends with batt_low at 0 leaves a set warning at 1.
- R8: A power-up test that ends with batt_low at 0 clears warn_pull_low to 0. Periodic testing then goes on as in R5.
- R9: If supply_ok falls during a window, load_en drops at the next edge and warn_pull_low keeps its value, whatever batt_low reads.
- R10: A change on batt_low outside a test window has no effect on warn_pull_low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; all delays are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply good (above the write-protect threshold) |
| batt_low | input | 1 | Comparator result, 1 when the loaded battery is below its trip point |
| load_en | output | 1 | Connects the battery test load while 1 |
| warn_pull_low | output | 1 | Open-drain enable for the warning line: 1 pulls it low, 0 releases it |

## Verification
A table of test outcomes checks the main function. The table mixes power-up tests and periodic tests, each with a good or a weak battery. This separates three cases: setting the warning, keeping it through a good periodic test, and clearing it through a good power-up test. The same table walk measures three timings. The power-up delay and the window length show that the recovery and window counts are exact. The gap between test starts shows that the interval is measured from the previous test start and restarts after a power-up. Pulses on batt_low between windows show that the comparator is only sampled inside a window. Directed cases then cut power during a window with the comparator both low and high, and apply reset while the warning is set. These show that an aborted test never touches the warning and that reset always releases it.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

  typedef enum logic [1:0] {
    ST_DOWN    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_TEST    = 2'd2,
    ST_IDLE    = 2'd3
  } bhm_state_e;

endpackage

// File: rtl/bhm_counter.sv
module bhm_counter #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic at_last
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  assign at_last = (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= at_last ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bhm_sequencer.sv
module bhm_sequencer
  import bhm_pkg::*;
#(
  parameter int RECOVERY_TICKS = 200,
  parameter int TEST_TICKS     = 1000,
  parameter int INTERVAL_TICKS = 86_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic load_en,
  output logic eval,
  output logic pwrup_eval
);
  bhm_state_e state, state_nx;
  logic       pwrup_flag;
  logic       rec_last, win_last, ivl_last;
  logic       start_test;

  // Recovery delay after the supply comes up
  bhm_counter #(.LIMIT(RECOVERY_TICKS)) u_rec_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state != ST_RECOVER),
    .en      (state == ST_RECOVER),
    .at_last (rec_last)
  );

  // Test window length
  bhm_counter #(.LIMIT(TEST_TICKS)) u_win_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state != ST_TEST),
    .en      (state == ST_TEST),
    .at_last (win_last)
  );

  // Interval measured from each test start
  bhm_counter #(.LIMIT(INTERVAL_TICKS)) u_ivl_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_test || state == ST_DOWN || state == ST_RECOVER),
    .en      (state == ST_TEST || state == ST_IDLE),
    .at_last (ivl_last)
  );

  always_comb begin
    state_nx = state;
    if (!supply_ok) begin
      state_nx = ST_DOWN;
    end else begin
      unique case (state)
        ST_DOWN:    state_nx = ST_RECOVER;
        ST_RECOVER: if (rec_last) state_nx = ST_TEST;
        ST_TEST:    if (win_last) state_nx = ST_IDLE;
        ST_IDLE:    if (ivl_last) state_nx = ST_TEST;
        default:    state_nx = ST_DOWN;
      endcase
    end
  end

  assign start_test = (state_nx == ST_TEST) && (state != ST_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_DOWN;
      pwrup_flag <= 1'b0;
    end else begin
      state <= state_nx;
      if (!supply_ok)                             pwrup_flag <= 1'b0;
      else if (state == ST_RECOVER && rec_last)   pwrup_flag <= 1'b1;
      else if (state == ST_TEST && win_last)      pwrup_flag <= 1'b0;
    end
  end

  assign load_en    = (state == ST_TEST);
  assign eval       = (state == ST_TEST) && win_last && supply_ok;
  assign pwrup_eval = eval && pwrup_flag;

  // R2: no load while the supply is down
  p_no_load_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !load_en);

  // R3: a window only opens while powered
  p_start_needs_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_en) |-> $past(supply_ok));

  // R4: a powered window always closes through an evaluation
  p_window_ends_in_eval_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(load_en) && $past(supply_ok)) |-> $past(eval));

  // R8: a power-up evaluation happens only inside a window
  p_pwrup_eval_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup_eval |-> load_en);
endmodule

// File: rtl/bhm_warn_latch.sv
module bhm_warn_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic eval,
  input  logic pwrup_eval,
  input  logic batt_low,
  output logic warn
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn <= 1'b0;
    end else if (eval) begin
      if (batt_low)        warn <= 1'b1;
      else if (pwrup_eval) warn <= 1'b0;
    end
  end

  // R6: weak reading at the end of a window sets the warning
  p_set_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && batt_low) |=> warn);

  // R7: a periodic good reading never clears it
  p_sticky_periodic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !pwrup_eval && warn) |=> warn);

  // R10: outside an evaluation the warning holds
  p_hold_outside_eval_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> $stable(warn));
endmodule

// File: rtl/batt_monitor.sv
module batt_monitor #(
  parameter int RECOVERY_TICKS = 200,
  parameter int TEST_TICKS     = 1000,
  parameter int INTERVAL_TICKS = 86_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic batt_low,
  output logic load_en,
  output logic warn_pull_low
);
  logic eval, pwrup_eval;

  bhm_sequencer #(
    .RECOVERY_TICKS (RECOVERY_TICKS),
    .TEST_TICKS     (TEST_TICKS),
    .INTERVAL_TICKS (INTERVAL_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .load_en    (load_en),
    .eval       (eval),
    .pwrup_eval (pwrup_eval)
  );

  bhm_warn_latch u_warn (
    .clk        (clk),
    .rst_n      (rst_n),
    .eval       (eval),
    .pwrup_eval (pwrup_eval),
    .batt_low   (batt_low),
    .warn       (warn_pull_low)
  );

  // R9: power loss mid-window removes the load and leaves the warning alone
  p_abort_keeps_warn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !supply_ok) |=> (!load_en && $stable(warn_pull_low)));
endmodule

// File: tb/batt_monitor_bench.sv
`timescale 1ns/1ps
module batt_monitor_bench;
  localparam int R = 5;
  localparam int T = 4;
  localparam int I = 20;

  // each entry {power-up test, batt_low during window, expected warning}
  localparam logic [2:0] VECS [0:8] = '{
    3'b100, 3'b000, 3'b011, 3'b001, 3'b001,
    3'b111, 3'b001, 3'b100, 3'b000
  };

  logic clk = 1'b0, rst_n = 1'b0, supply_ok = 1'b0, batt_low = 1'b0;
  logic load_en, warn_pull_low;
  int cyc = 0;
  int n_chk = 0, n_fail = 0;

  batt_monitor #(.RECOVERY_TICKS(R), .TEST_TICKS(T), .INTERVAL_TICKS(I)) u_batt_monitor (
    .clk (clk), .rst_n (rst_n), .supply_ok (supply_ok), .batt_low (batt_low),
    .load_en (load_en), .warn_pull_low (warn_pull_low)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_load(output int t);
    int guard = 0;
    while (!load_en && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    t = cyc;
  endtask

  function automatic string tag_of(input logic [2:0] v);
    if (v[1]) return "R6 set";
    if (v[2]) return "R8 clear";
    return "R7 sticky";
  endfunction

  task automatic power_up(output int st);
    int c0;
    supply_ok = 1'b1;
    c0 = cyc;
    @(negedge clk);
    wait_load(st);
    chk("R3 power-up delay", st, c0 + 1 + R);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int prev, st, len;
    logic w;
    repeat (3) @(negedge clk);
    chk("R1 load in reset", load_en, 0);
    chk("R1 warn in reset", warn_pull_low, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 load after reset", load_en, 0);
    chk("R1 warn after reset", warn_pull_low, 0);
    prev = 0;

    for (int k = 0; k < 9; k++) begin
      if (VECS[k][2]) begin
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 no load while down", load_en, 0);
        power_up(st);
      end else begin
        wait_load(st);
        chk("R5 interval", st, prev + I);
      end
      batt_low = VECS[k][1];
      len = 0;
      while (load_en && len < 100) begin
        len++;
        @(negedge clk);
      end
      chk("R4 window length", len, T);
      chk(tag_of(VECS[k]), warn_pull_low, VECS[k][0]);
      batt_low = 1'b0;
      prev = st;
      repeat (2) @(negedge clk);
      batt_low = 1'b1;
      repeat (3) @(negedge clk);
      batt_low = 1'b0;
      chk("R10 idle comparator ignored", warn_pull_low, VECS[k][0]);
      chk("R10 no load in idle", load_en, 0);
    end

    // R9: abort with weak battery, warning clear stays clear
    wait_load(st);
    batt_low = 1'b1;
    repeat (2) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R9 load dropped", load_en, 0);
    batt_low = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 warn unchanged (clear)", warn_pull_low, 0);

    // set warning via a power-up test with weak battery
    power_up(st);
    batt_low = 1'b1;
    repeat (T) @(negedge clk);
    batt_low = 1'b0;
    chk("R6 power-up weak sets", warn_pull_low, 1);
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);

    // R9: abort with good battery during power-up test, warning stays set
    power_up(st);
    repeat (2) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R9 load dropped", load_en, 0);
    repeat (2) @(negedge clk);
    w = warn_pull_low;
    chk("R9 warn unchanged (set)", w, 1);

    // R1: reset releases a set warning
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears warn", warn_pull_low, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 load after reset", load_en, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule